// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

The block watches a row of interrupt input pins and turns each request into a delivery message: an 8-bit vector, a 16-bit destination processor identifier and a 3-bit delivery mode. Every pin owns one redirection entry. The entry sets the pin's polarity, chooses edge or level sensing, and holds a mask bit. The message leaves on a valid/ready channel. When several pins request in the same cycle, the lowest pin index wins. Only one message is presented at a time, and it stays unchanged until it is accepted.

Software reaches the block through an indirect window. A write to the select port chooses a register. The data port then writes that register, and the read port returns its value. Select value 0x01 is a version register. Select 0x10 + 2·i is the low word of entry i, and 0x11 + 2·i is its high word. Software writes the high word first. The destination it carries reaches the delivery path only when the low word of the same entry is written.

Level-sensed entries keep a remote-pending flag. The flag is set when the entry's message is taken from the arbiter, and it blocks further deliveries from that entry. An end-of-interrupt carrying the entry's vector clears the flag. Several level entries may share one vector, and a single end-of-interrupt releases all of them.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset, every low word reads 0x0001_0000 (only the mask bit, bit 16, set), every high word reads 0, and msg_valid is low.
- R2: The version register (select 0x01) reads VERSION in bits 7:0 and NUM_PINS-1 in bits 23:16, with every other bit zero.
- R3: The low-word layout is: vector in bits 7:0, mode in bits 10:8, polarity in bit 13, remote-pending in bit 14 (read-only, writes ignored), trigger in bit 15 (1 = level), mask in bit 16. The remaining bits read zero, and the written fields read back unchanged.
- R4: The high word holds the destination in bits 31:16, and bits 15:0 read zero. A new destination is used by deliveries only after the next low-word write to the same entry.
- R5: The pin is XORed with polarity (0 = active-high, 1 = active-low). An unmasked level entry whose pin is active delivers its vector, committed destination and mode. An inactive pin delivers nothing.
- R6: A delivered level entry sets remote-pending and makes no further delivery while it is set. An end-of-interrupt with the entry's vector clears it in every level entry sharing that vector, so entries that are still active deliver again.
- R7: An unmasked edge entry delivers once for each inactive-to-active transition. Holding the pin active produces no further delivery.
- R8: A transition that occurs while the entry is masked is discarded. Clearing the mask afterwards produces no delivery.
- R9: Among simultaneous requests, the lowest pin index is delivered first. While msg_ready is low, msg_valid and the message fields hold steady.
- R10: An end-of-interrupt whose vector matches no waiting entry leaves remote-pending set and causes no delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| win_sel_we | input | 1 | Load the select register from win_wdata[7:0] |
| win_data_we | input | 1 | Write win_wdata to the selected register |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Contents of the selected register |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector that the end-of-interrupt names |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Delivered vector |
| msg_dest | output | 16 | Destination (processor ID in the upper byte, extended ID in the lower byte) |
| msg_mode | output | 3 | Delivery mode (0 fixed, 1 lowest priority, 2 PMI, 5 INIT) |

## Verification
The hardest situation to create from the ports is two level entries that share a vector and are both waiting on remote-pending while their pins stay active. One end-of-interrupt must then release both entries, and they must deliver again in index order. The bench reaches this state by asserting both pins in the same cycle, draining both messages, and issuing first an end-of-interrupt for an unrelated vector and then one for the shared vector. It also stages a high-word write without the matching low-word commit, and confirms that the old destination keeps being delivered.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int POL_BIT   = 13;
  localparam int RPEND_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 16;

  localparam logic [7:0] SEL_VERSION    = 8'h01;
  localparam logic [7:0] SEL_TABLE_BASE = 8'h10;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_PMI    = 3'd2,
    DM_INIT   = 3'd5
  } dmode_e;

  typedef struct packed {
    logic [7:0]  vector;
    logic [15:0] dest;
    logic [2:0]  mode;
  } irc_msg_t;
endpackage

// File: rtl/irc_slot.sv
module irc_slot
  import irc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_raw,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        eoi_valid,
  input  logic [7:0]  eoi_vector,
  input  logic        grant,
  output logic [31:0] lo_word,
  output logic [31:0] hi_word,
  output irc_msg_t    msg,
  output logic        req
);
  logic [7:0]  vec_q, vec_d;
  logic [2:0]  mode_q, mode_d;
  logic        pol_q, pol_d, lvl_q, lvl_d, mask_q, mask_d;
  logic        rpend_q, rpend_d, epend_q, epend_d, prev_q, prev_d;
  logic [15:0] stage_q, stage_d, dest_q, dest_d;
  logic        active, rise, eoi_hit;

  assign active  = pin_raw ^ pol_q;
  assign rise    = active & ~prev_q;
  assign eoi_hit = eoi_valid & lvl_q & (eoi_vector == vec_q);

  always_comb begin
    vec_d   = vec_q;
    mode_d  = mode_q;
    pol_d   = pol_q;
    lvl_d   = lvl_q;
    mask_d  = mask_q;
    rpend_d = rpend_q;
    epend_d = epend_q;
    stage_d = stage_q;
    dest_d  = dest_q;
    prev_d  = active;
    if (wr_hi) stage_d = wdata[DEST_LSB +: 16];
    if (!lvl_q && rise && !mask_q) epend_d = 1'b1;
    if (eoi_hit) rpend_d = 1'b0;
    if (grant) begin
      if (lvl_q) rpend_d = 1'b1;
      else       epend_d = 1'b0;
    end
    if (wr_lo) begin
      vec_d   = wdata[VEC_LSB +: 8];
      mode_d  = wdata[MODE_LSB +: 3];
      pol_d   = wdata[POL_BIT];
      lvl_d   = wdata[TRIG_BIT];
      mask_d  = wdata[MASK_BIT];
      dest_d  = stage_q;
      epend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      mode_q  <= '0;
      pol_q   <= 1'b0;
      lvl_q   <= 1'b0;
      mask_q  <= 1'b1;
      rpend_q <= 1'b0;
      epend_q <= 1'b0;
      stage_q <= '0;
      dest_q  <= '0;
      prev_q  <= 1'b0;
    end else begin
      vec_q   <= vec_d;
      mode_q  <= mode_d;
      pol_q   <= pol_d;
      lvl_q   <= lvl_d;
      mask_q  <= mask_d;
      rpend_q <= rpend_d;
      epend_q <= epend_d;
      stage_q <= stage_d;
      dest_q  <= dest_d;
      prev_q  <= prev_d;
    end
  end

  assign req     = ~mask_q & (lvl_q ? (active & ~rpend_q) : epend_q);
  assign lo_word = {15'b0, mask_q, lvl_q, rpend_q, pol_q, 2'b00, mode_q, vec_q};
  assign hi_word = {stage_q, 16'b0};
  assign msg     = '{vector: vec_q, dest: dest_q, mode: mode_q};
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic             enable,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = enable;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irc_window.sv
module irc_window
  import irc_pkg::*;
#(
  parameter int         N       = 8,
  parameter logic [7:0] VERSION = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic              data_we,
  input  logic [31:0]       wdata,
  input  logic [N-1:0][31:0] lo_words,
  input  logic [N-1:0][31:0] hi_words,
  output logic [N-1:0]      wr_lo,
  output logic [N-1:0]      wr_hi,
  output logic [31:0]       rdata
);
  logic [7:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (sel_we) sel_d = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  always_comb begin
    wr_lo = '0;
    wr_hi = '0;
    rdata = '0;
    if (sel_q == SEL_VERSION) rdata = {8'h00, 8'(N - 1), 8'h00, VERSION};
    for (int i = 0; i < N; i++) begin
      if (sel_q == SEL_TABLE_BASE + 8'(2 * i)) begin
        wr_lo[i] = data_we;
        rdata    = lo_words[i];
      end
      if (sel_q == SEL_TABLE_BASE + 8'(2 * i + 1)) begin
        wr_hi[i] = data_we;
        rdata    = hi_words[i];
      end
    end
  end
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irc_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pins,
  input  logic                win_sel_we,
  input  logic                win_data_we,
  input  logic [31:0]         win_wdata,
  output logic [31:0]         win_rdata,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_mode
);
  logic [NUM_PINS-1:0][31:0] lo_words, hi_words;
  logic [NUM_PINS-1:0]       wr_lo, wr_hi, req_w, grant_w;
  logic [IDX_W-1:0]          win_idx;
  irc_msg_t                  slot_msg [NUM_PINS];
  irc_msg_t                  msg_q, msg_d;
  logic                      valid_q, valid_d;

  irc_window #(.N(NUM_PINS), .VERSION(VERSION)) u_window (
    .clk(clk), .rst_n(rst_n), .sel_we(win_sel_we), .data_we(win_data_we),
    .wdata(win_wdata), .lo_words(lo_words), .hi_words(hi_words),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rdata(win_rdata)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
    irc_slot u_slot (
      .clk(clk), .rst_n(rst_n), .pin_raw(irq_pins[g]),
      .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]), .wdata(win_wdata),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .grant(grant_w[g]),
      .lo_word(lo_words[g]), .hi_word(hi_words[g]), .msg(slot_msg[g]),
      .req(req_w[g])
    );
  end

  irc_arbiter #(.N(NUM_PINS)) u_arb (
    .req(req_w), .enable(~valid_q), .grant(grant_w), .idx(win_idx)
  );

  always_comb begin
    valid_d = valid_q;
    msg_d   = msg_q;
    if (valid_q && msg_ready) valid_d = 1'b0;
    if (|grant_w) begin
      valid_d = 1'b1;
      msg_d   = slot_msg[win_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      msg_q   <= msg_d;
    end
  end

  assign msg_valid  = valid_q;
  assign msg_vector = msg_q.vector;
  assign msg_dest   = msg_q.dest;
  assign msg_mode   = msg_q.mode;
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [7:0]   msg_vector,
  input logic [15:0]  msg_dest,
  input logic [2:0]   msg_mode,
  input logic [N-1:0] grant,
  input logic [N-1:0] req
);
  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                   $stable(msg_dest) && $stable(msg_mode)));
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R9
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> !msg_valid);
  // R9
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (((grant - 1'b1) & req) == '0));
  // R5
  msg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|req));
endmodule

bind irq_redirect_ctrl irc_checker #(.N(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode),
  .grant(grant_w), .req(req_w)
);

// File: tb/irq_redirect_ctrl_tb.sv
module irq_redirect_ctrl_tb;
  localparam int NP = 4;
  localparam logic [7:0] VER = 8'h21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] irq_pins = '0;
  logic win_sel_we = 0, win_data_we = 0, eoi_valid = 0, msg_ready = 0;
  logic [31:0] win_wdata = '0;
  logic [7:0]  eoi_vector = '0;
  logic [31:0] win_rdata;
  logic msg_valid;
  logic [7:0] msg_vector;
  logic [15:0] msg_dest;
  logic [2:0] msg_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_redirect_ctrl #(.NUM_PINS(NP), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .win_sel_we(win_sel_we),
    .win_data_we(win_data_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_mode(msg_mode)
  );

  function automatic logic [31:0] lo_val(logic [7:0] v, logic [2:0] m,
                                         logic p, logic l, logic k);
    return {15'b0, k, l, 1'b0, p, 2'b00, m, v};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] sel, logic [31:0] d);
    @(negedge clk); win_sel_we = 1; win_wdata = {24'b0, sel};
    @(negedge clk); win_sel_we = 0; win_data_we = 1; win_wdata = d;
    @(negedge clk); win_data_we = 0;
  endtask

  task automatic rd(logic [7:0] sel, output logic [31:0] d);
    @(negedge clk); win_sel_we = 1; win_wdata = {24'b0, sel};
    @(negedge clk); win_sel_we = 0; d = win_rdata;
  endtask

  task automatic wr_lo(int p, logic [31:0] d); wr(8'h10 + 8'(2*p), d); endtask
  task automatic wr_hi(int p, logic [15:0] dst); wr(8'h11 + 8'(2*p), {dst, 16'hFFFF}); endtask

  task automatic eoi(logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vector = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic expect_msg(string tag, logic [7:0] v, logic [15:0] dst, logic [2:0] m);
    int w = 0;
    while (!msg_valid && w < 10) begin @(negedge clk); w++; end
    check(tag, {5'b0, msg_valid, msg_vector, msg_dest, msg_mode}, {5'b0, 1'b1, v, dst, m});
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  task automatic expect_quiet(string tag, int n);
    logic seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); seen |= msg_valid; end
    check(tag, {31'b0, seen}, 32'b0);
  endtask

  task automatic rpend(string tag, int p, logic exp);
    logic [31:0] d;
    rd(8'h10 + 8'(2*p), d);
    check(tag, {31'b0, d[14]}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 msg_valid", {31'b0, msg_valid}, 32'b0);
    for (int p = 0; p < NP; p++) begin
      rd(8'h10 + 8'(2*p), d); check("R1 lo", d, 32'h0001_0000);
      rd(8'h11 + 8'(2*p), d); check("R1 hi", d, 32'h0);
    end
    // R2 version
    rd(8'h01, d); check("R2 version", d, {8'h00, 8'(NP-1), 8'h00, VER});
    // R3 layout readback, remote bit and spare bits ignored on write
    for (int p = 0; p < NP; p++) begin
      wr_lo(p, lo_val(8'h40 + 8'(p), 3'(p), 1'b0, 1'(p & 1), 1'b1) | 32'hFFFE_5800);
      rd(8'h10 + 8'(2*p), d);
      check("R3 lo readback", d, lo_val(8'h40 + 8'(p), 3'(p), 1'b0, 1'(p & 1), 1'b1));
    end
    for (int p = 0; p < NP; p++) wr_lo(p, lo_val(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
    // R5/R6 sweep over pins and polarities, level mode
    for (int p = 0; p < NP; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] v = 8'h20 + 8'(2*p + pol);
        logic [15:0] dst = 16'h0100 + 16'(16*p + pol);
        logic [2:0] m = 3'((p + pol) % 8);
        wr_hi(p, dst);
        wr_lo(p, lo_val(v, m, 1'(pol), 1'b1, 1'b1));
        irq_pins[p] = 1'(pol);
        wr_lo(p, lo_val(v, m, 1'(pol), 1'b1, 1'b0));
        expect_quiet("R5 inactive pin", 4);
        irq_pins[p] = ~1'(pol);
        expect_msg("R5 level delivery", v, dst, m);
        expect_quiet("R6 blocked while pending", 4);
        rpend("R6 pending set", p, 1'b1);
        irq_pins[p] = 1'(pol);
        eoi(v);
        rpend("R6 pending cleared", p, 1'b0);
        wr_lo(p, lo_val(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
        irq_pins[p] = 1'b0;
      end
    end
    // R4 staged destination commit
    wr_hi(1, 16'h1111);
    wr_lo(1, lo_val(8'h55, 3'd1, 1'b0, 1'b1, 1'b0));
    irq_pins[1] = 1; expect_msg("R4 first dest", 8'h55, 16'h1111, 3'd1);
    irq_pins[1] = 0; eoi(8'h55);
    wr_hi(1, 16'h2222);
    rd(8'h13, d); check("R4 hi readback", d, 32'h2222_0000);
    irq_pins[1] = 1; expect_msg("R4 uncommitted dest", 8'h55, 16'h1111, 3'd1);
    // R10 unrelated end-of-interrupt
    eoi(8'h56);
    rpend("R10 pending kept", 1, 1'b1);
    expect_quiet("R10 no delivery", 4);
    irq_pins[1] = 0; eoi(8'h55);
    wr_lo(1, lo_val(8'h55, 3'd1, 1'b0, 1'b1, 1'b0));
    irq_pins[1] = 1; expect_msg("R4 committed dest", 8'h55, 16'h2222, 3'd1);
    irq_pins[1] = 0; eoi(8'h55);
    wr_lo(1, lo_val(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
    // R6 shared vector
    wr_hi(2, 16'h0202); wr_lo(2, lo_val(8'h77, 3'd0, 1'b0, 1'b1, 1'b0));
    wr_hi(3, 16'h0303); wr_lo(3, lo_val(8'h77, 3'd0, 1'b0, 1'b1, 1'b0));
    @(negedge clk); irq_pins[3:2] = 2'b11;
    expect_msg("R6 shared first", 8'h77, 16'h0202, 3'd0);
    expect_msg("R6 shared second", 8'h77, 16'h0303, 3'd0);
    expect_quiet("R6 shared blocked", 4);
    eoi(8'h12);
    expect_quiet("R10 shared untouched", 4);
    eoi(8'h77);
    expect_msg("R6 release first", 8'h77, 16'h0202, 3'd0);
    expect_msg("R6 release second", 8'h77, 16'h0303, 3'd0);
    irq_pins[3:2] = 2'b00; eoi(8'h77);
    rpend("R6 pin2 cleared", 2, 1'b0);
    rpend("R6 pin3 cleared", 3, 1'b0);
    wr_lo(2, lo_val(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
    wr_lo(3, lo_val(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
    // R7 edge once per transition
    wr_hi(0, 16'h0A0B); wr_lo(0, lo_val(8'h90, 3'd2, 1'b0, 1'b0, 1'b0));
    irq_pins[0] = 1; expect_msg("R7 edge", 8'h90, 16'h0A0B, 3'd2);
    expect_quiet("R7 held level no repeat", 6);
    irq_pins[0] = 0; @(negedge clk);
    irq_pins[0] = 1; expect_msg("R7 second edge", 8'h90, 16'h0A0B, 3'd2);
    // R8 masked edge dropped
    irq_pins[0] = 0;
    wr_lo(0, lo_val(8'h90, 3'd2, 1'b0, 1'b0, 1'b1));
    irq_pins[0] = 1; repeat (3) @(negedge clk);
    wr_lo(0, lo_val(8'h90, 3'd2, 1'b0, 1'b0, 1'b0));
    expect_quiet("R8 dropped edge", 6);
    irq_pins[0] = 0; @(negedge clk);
    irq_pins[0] = 1; expect_msg("R8 later edge", 8'h90, 16'h0A0B, 3'd2);
    irq_pins[0] = 0;
    wr_lo(0, lo_val(8'h0, 3'd0, 1'b0, 1'b0, 1'b1));
    // R9 priority and hold
    wr_hi(1, 16'h00A1); wr_lo(1, lo_val(8'hA1, 3'd5, 1'b0, 1'b0, 1'b0));
    wr_hi(2, 16'h00A2); wr_lo(2, lo_val(8'hA2, 3'd0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); irq_pins[2:1] = 2'b11;
    repeat (4) @(negedge clk);
    check("R9 winner", {23'b0, msg_valid, msg_vector}, {23'b0, 1'b1, 8'hA1});
    repeat (5) @(negedge clk);
    check("R9 held", {7'b0, msg_valid, msg_vector, msg_dest}, {7'b0, 1'b1, 8'hA1, 16'h00A1});
    expect_msg("R9 first", 8'hA1, 16'h00A1, 3'd5);
    expect_msg("R9 second", 8'hA2, 16'h00A2, 3'd0);
    expect_quiet("R9 no extra", 4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule